// File: doc/BRIEF.md
# Filter-VM Integer Execution Unit

This unit executes the arithmetic, logic, shift and byte-order instructions of a 64-bit filter virtual machine. Each accepted transaction carries a decoded 8-bit opcode, the current destination register value, the source register value and a 32-bit immediate. The unit produces the new destination value and an illegal-instruction flag one cycle later. Register file access, fetch, memory and branches belong to neighbouring blocks.

One opcode byte picks the operation, whether the second operand is the register or the immediate, and whether the operation works on the whole 64-bit word or on the low 32 bits with the result zero-extended. A byte-order conversion shares the same opcode space and takes its width from the immediate. A parameter adds signed divide and signed remainder.

Both edges are valid/ready streams. An input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a consumer that keeps `out_ready` high gets one result per cycle. While `out_valid` is high and `out_ready` is low, the result and flag hold still and no new input is taken.

Top module: `filter_alu`

## Requirements
- R1: Opcode bits 7:4 select the operation, bit 3 selects the second operand, and bits 2:0 select the class. Class 3'b111 computes on 64 bits and class 3'b100 computes on the low 32 bits. Any other class is illegal.
- R2: When opcode bit 3 is 0, the second operand is the immediate sign-extended to 64 bits, of which the 32-bit class uses the low half. When bit 3 is 1, the second operand is the source register.
- R3: The operation codes behave as follows. ADD=0x0, SUB=0x1 and MUL=0x2 wrap at the operating width. OR=0x4, AND=0x5 and XOR=0xA are bitwise. NEG=0x8 returns the negated destination and ignores the second operand. MOV=0xB returns the second operand and ignores the destination.
- R4: A 32-bit class result has bits 63:32 equal to zero.
- R5: LSH=0x6 shifts left, RSH=0x7 shifts right logically and ARSH=0xC shifts right arithmetically. The shift amount is the second operand masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class.
- R6: DIV=0x3 and MOD=0x9 are unsigned. A zero divisor gives 0 for DIV and returns the dividend for MOD.
- R7: With `EXT_SDIV`=1, SDIV=0xE and SMOD=0xF divide as signed values, truncating toward zero, and the remainder takes the sign of the dividend. A zero divisor behaves as in R6. A divisor of -1 gives the wrapped negation of the dividend and a remainder of 0.
- R8: END=0xD is legal only in class 3'b100 with an immediate of 16, 32 or 64. With bit 3 = 0 it keeps the low width bits of the destination, zero-extended. With bit 3 = 1 it reverses the byte order within that width and zeroes the bits above it. Any other class or width for END is illegal.
- R9: An illegal opcode raises `out_illegal` and returns the destination value unchanged. SDIV and SMOD are illegal when `EXT_SDIV`=0.
- R10: `in_ready` = !`out_valid` || `out_ready`. An accepted input's result appears with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_result` and `out_illegal` stay stable.
- R11: After reset, `out_valid`, `out_result` and `out_illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_opcode | input | 8 | Operation, operand select and class |
| in_dst | input | 64 | Current destination register value |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Immediate field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | New destination value |
| out_illegal | output | 1 | Opcode was not executable |

## Verification
Two events can fall in the same cycle: the output register drains a finished result and it captures the next accepted input. The sweep provokes this on every cycle by keeping both `in_valid` and `out_ready` high. A transaction presented at one falling edge is judged at the next, so an off-by-one acceptance would surface as the neighbouring operation's value. A separate back-pressure phase stalls the consumer while an input waits. It then checks that the held result does not move and that `in_ready` stays low, and finally releases the drain and the capture together.

// File: rtl/filter_alu_pkg.sv
package filter_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_LSH  = 4'h6,
    OP_RSH  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'hA,
    OP_MOV  = 4'hB,
    OP_ARSH = 4'hC,
    OP_END  = 4'hD,
    OP_SDIV = 4'hE,
    OP_SMOD = 4'hF
  } alu_op_e;

  localparam logic [2:0] CLS_NARROW = 3'b100;
  localparam logic [2:0] CLS_WIDE   = 3'b111;

  // byte-order width selector
  localparam logic [1:0] BO_16 = 2'd0;
  localparam logic [1:0] BO_32 = 2'd1;
  localparam logic [1:0] BO_64 = 2'd2;

endpackage

// File: rtl/filter_alu_decode.sv
module filter_alu_decode
  import filter_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [7:0]      opcode,
  input  logic [XLEN-1:0] src_val,
  input  logic [31:0]     imm,
  output alu_op_e         op,
  output logic            narrow,
  output logic            class_ok,
  output logic            is_bswap,
  output logic            bswap_big,
  output logic [1:0]      bswap_sel,
  output logic            bswap_ok,
  output logic [XLEN-1:0] operand_b
);

  logic [2:0] cls;
  logic       use_reg;

  assign op        = alu_op_e'(opcode[7:4]);
  assign use_reg   = opcode[3];
  assign cls       = opcode[2:0];
  assign narrow    = (cls == CLS_NARROW);
  assign class_ok  = narrow || (cls == CLS_WIDE);
  assign is_bswap  = (op == OP_END);
  assign bswap_big = use_reg;

  assign operand_b = use_reg ? src_val : {{(XLEN-32){imm[31]}}, imm};

  always_comb begin
    bswap_ok  = 1'b1;
    bswap_sel = BO_64;
    case (imm)
      32'd16:  bswap_sel = BO_16;
      32'd32:  bswap_sel = BO_32;
      32'd64:  bswap_sel = BO_64;
      default: bswap_ok  = 1'b0;
    endcase
  end

endmodule

// File: rtl/filter_alu_core.sv
module filter_alu_core
  import filter_alu_pkg::*;
#(
  parameter int W        = 64,
  parameter bit EXT_SDIV = 1'b1
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         supported
);

  localparam int SHW = $clog2(W);

  logic [SHW-1:0] sh;
  logic           b_zero;
  logic [W-1:0]   sq;
  logic [W-1:0]   sr;

  assign sh     = b[SHW-1:0];
  assign b_zero = (b == '0);

  generate
    if (EXT_SDIV) begin : g_sdiv
      always_comb begin
        if (b_zero) begin
          sq = '0;
          sr = a;
        end else if (&b) begin
          // divisor of -1: wrapped negation, avoids the overflow case
          sq = '0 - a;
          sr = '0;
        end else begin
          sq = W'($signed(a) / $signed(b));
          sr = W'($signed(a) % $signed(b));
        end
      end
    end else begin : g_no_sdiv
      assign sq = '0;
      assign sr = '0;
    end
  endgenerate

  always_comb begin
    supported = 1'b1;
    res       = a;
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_DIV:  res = b_zero ? '0 : a / b;
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_LSH:  res = a << sh;
      OP_RSH:  res = a >> sh;
      OP_NEG:  res = '0 - a;
      OP_MOD:  res = b_zero ? a : a % b;
      OP_XOR:  res = a ^ b;
      OP_MOV:  res = b;
      OP_ARSH: res = W'($signed(a) >>> sh);
      OP_SDIV: begin res = sq; supported = EXT_SDIV; end
      OP_SMOD: begin res = sr; supported = EXT_SDIV; end
      default: supported = 1'b0;
    endcase
  end

endmodule

// File: rtl/filter_alu_bswap.sv
module filter_alu_bswap
  import filter_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  logic            to_big,
  input  logic [1:0]      sel,
  output logic [XLEN-1:0] res
);

  localparam int NB = XLEN / 8;

  int nb;

  always_comb begin
    case (sel)
      BO_16:   nb = 2;
      BO_32:   nb = 4;
      default: nb = NB;
    endcase
  end

  always_comb begin
    res = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < nb) begin
        if (to_big) res[8*i +: 8] = val[8*(nb-1-i) +: 8];
        else        res[8*i +: 8] = val[8*i +: 8];
      end
    end
  end

endmodule

// File: rtl/filter_alu.sv
module filter_alu
  import filter_alu_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter bit EXT_SDIV = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_opcode,
  input  logic [XLEN-1:0] in_dst,
  input  logic [XLEN-1:0] in_src,
  input  logic [31:0]     in_imm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);

  localparam int HALF = XLEN / 2;

  alu_op_e         op;
  logic            narrow, class_ok, is_bswap, bswap_big, bswap_ok;
  logic [1:0]      bswap_sel;
  logic [XLEN-1:0] operand_b;
  logic [XLEN-1:0] wide_res, bswap_res;
  logic [HALF-1:0] narrow_res;
  logic            wide_sup, narrow_sup;
  logic            illegal;
  logic [XLEN-1:0] next_res;
  logic            in_fire;

  filter_alu_decode #(.XLEN(XLEN)) u_decode (
    .opcode    (in_opcode),
    .src_val   (in_src),
    .imm       (in_imm),
    .op        (op),
    .narrow    (narrow),
    .class_ok  (class_ok),
    .is_bswap  (is_bswap),
    .bswap_big (bswap_big),
    .bswap_sel (bswap_sel),
    .bswap_ok  (bswap_ok),
    .operand_b (operand_b)
  );

  filter_alu_core #(.W(XLEN), .EXT_SDIV(EXT_SDIV)) u_core_wide (
    .op        (op),
    .a         (in_dst),
    .b         (operand_b),
    .res       (wide_res),
    .supported (wide_sup)
  );

  filter_alu_core #(.W(HALF), .EXT_SDIV(EXT_SDIV)) u_core_narrow (
    .op        (op),
    .a         (in_dst[HALF-1:0]),
    .b         (operand_b[HALF-1:0]),
    .res       (narrow_res),
    .supported (narrow_sup)
  );

  filter_alu_bswap #(.XLEN(XLEN)) u_bswap (
    .val    (in_dst),
    .to_big (bswap_big),
    .sel    (bswap_sel),
    .res    (bswap_res)
  );

  always_comb begin
    if (!class_ok)      illegal = 1'b1;
    else if (is_bswap)  illegal = !narrow || !bswap_ok;
    else                illegal = narrow ? !narrow_sup : !wide_sup;
  end

  always_comb begin
    if (illegal)       next_res = in_dst;
    else if (is_bswap) next_res = bswap_res;
    else if (narrow)   next_res = {{HALF{1'b0}}, narrow_res};
    else               next_res = wide_res;
  end

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (in_fire) begin
      out_valid   <= 1'b1;
      out_result  <= next_res;
      out_illegal <= illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  a_r10_fire_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_opcode[2:0] == CLS_NARROW && in_opcode[7:4] != 4'hD && !illegal)
      |=> (out_result[XLEN-1:HALF] == '0));

  a_r9_dst_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && illegal) |=> (out_illegal && out_result == $past(in_dst)));

  a_r6_div_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_opcode[7:4] == 4'h3 && in_opcode[2:0] == CLS_WIDE && operand_b == '0)
      |=> (out_result == '0 && !out_illegal));

endmodule

// File: tb/filter_alu_bench.sv
module filter_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic [7:0]  in_opcode = '0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic [31:0] in_imm = '0;
  logic        in_ready, out_valid, out_illegal;
  logic [63:0] out_result;
  logic        nx_in_ready, nx_out_valid, nx_out_illegal;
  logic [63:0] nx_out_result;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  filter_alu u_filter_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_illegal(out_illegal)
  );

  filter_alu #(.EXT_SDIV(1'b0)) u_filter_alu_noext (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(nx_in_ready),
    .in_opcode(in_opcode), .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .out_valid(nx_out_valid), .out_ready(out_ready), .out_result(nx_out_result),
    .out_illegal(nx_out_illegal)
  );

  localparam logic [63:0] DV [6] = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_8000_0000};
  localparam logic [63:0] SV [6] = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0007, 64'h1234_5678_FFFF_FFFF, 64'h0000_0003_0000_0021};
  localparam logic [31:0] IV [6] = '{32'd0, 32'd16, 32'd32, 32'd64,
    32'hFFFF_FFFF, 32'h8000_0003};

  function automatic logic [63:0] sx(input logic [63:0] v, input int w);
    return (w == 32) ? {{32{v[31]}}, v[31:0]} : v;
  endfunction

  function automatic logic [63:0] calc(input logic [3:0] op, input logic [63:0] a,
                                       input logic [63:0] b, input int w,
                                       input bit ext, output bit bad_op);
    logic [63:0] m, am, bm, as, bs, ma, mb, q, r, t;
    int sh;
    m  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    am = a & m;
    bm = b & m;
    sh = (w == 64) ? int'(b[5:0]) : int'(b[4:0]);
    as = sx(am, w);
    bs = sx(bm, w);
    bad_op = 1'b0;
    t = 64'h0;
    case (op)
      4'h0: t = am + bm;
      4'h1: t = am - bm;
      4'h2: t = am * bm;
      4'h3: t = (bm == 0) ? 64'h0 : am / bm;
      4'h4: t = am | bm;
      4'h5: t = am & bm;
      4'h6: t = am << sh;
      4'h7: t = am >> sh;
      4'h8: t = 64'h0 - am;
      4'h9: t = (bm == 0) ? am : am % bm;
      4'hA: t = am ^ bm;
      4'hB: t = bm;
      4'hC: t = 64'($signed(as) >>> sh);
      4'hE, 4'hF: begin
        if (!ext) bad_op = 1'b1;
        else if (bm == 0) t = (op == 4'hE) ? 64'h0 : am;
        else begin
          ma = as[63] ? 64'h0 - as : as;
          mb = bs[63] ? 64'h0 - bs : bs;
          q  = ma / mb;
          r  = ma % mb;
          if (as[63] ^ bs[63]) q = 64'h0 - q;
          if (as[63]) r = 64'h0 - r;
          t = (op == 4'hE) ? q : r;
        end
      end
      default: bad_op = 1'b1;
    endcase
    return t & m;
  endfunction

  task automatic model(input logic [7:0] opc, input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] im, input bit ext,
                       output logic [63:0] r, output bit ill);
    logic [63:0] b;
    int w, nb;
    ill = 1'b0;
    r = 64'h0;
    b = opc[3] ? s : {{32{im[31]}}, im};   // R2 operand selection
    if (opc[2:0] != 3'b100 && opc[2:0] != 3'b111) ill = 1'b1;
    else if (opc[7:4] == 4'hD) begin
      if (opc[2:0] != 3'b100 || !(im == 16 || im == 32 || im == 64)) ill = 1'b1;
      else begin
        nb = int'(im) / 8;
        for (int i = 0; i < nb; i++)
          r[8*i +: 8] = opc[3] ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
      end
    end else begin
      w = (opc[2:0] == 3'b100) ? 32 : 64;
      r = calc(opc[7:4], d, b, w, ext, ill);
    end
    if (ill) r = d;
  endtask

  function automatic string tag_of(input logic [7:0] opc, input bit ext);
    if (opc[2:0] != 3'b100 && opc[2:0] != 3'b111) return "R1";
    case (opc[7:4])
      4'h3, 4'h9: return "R6";
      4'h6, 4'h7, 4'hC: return "R5";
      4'hD: return "R8";
      4'hE, 4'hF: return ext ? "R7" : "R9";
      default: return (opc[2:0] == 3'b100) ? "R3/R4" : "R3";
    endcase
  endfunction

  task automatic check(input string tag, input bit v, input logic [63:0] got,
                       input bit gill, input logic [63:0] exp, input bit eill,
                       input logic [7:0] opc);
    total++;
    if (!v || got !== exp || gill !== eill) begin
      bad++;
      $display("FAIL %s op=%02h valid=%0b got=%016h/%0b expected=%016h/%0b",
               tag, opc, v, got, gill, exp, eill);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] e1, e2, ea, eb;
    logic [7:0]  po, opa, opb;
    bit i1, i2, pend;
    pend = 1'b0;
    po = '0; e1 = '0; e2 = '0; i1 = 1'b0; i2 = 1'b0;

    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_result !== 64'h0 || out_illegal !== 1'b0) begin
      bad++;
      $display("FAIL R11 got v=%0b r=%016h i=%0b expected 0/0/0", out_valid, out_result, out_illegal);
    end
    rst_n = 1'b1;

    // sweep: every opcode, back-to-back, drain and capture in the same cycle (R10)
    for (int op = 0; op < 256; op++) begin
      for (int di = 0; di < 6; di++) begin
        for (int si = 0; si < 6; si++) begin
          for (int ii = 0; ii < 6; ii++) begin
            @(negedge clk);
            if (pend) begin
              check(tag_of(po, 1'b1), out_valid, out_result, out_illegal, e1, i1, po);
              check(tag_of(po, 1'b0), nx_out_valid, nx_out_result, nx_out_illegal, e2, i2, po);
            end
            in_valid  = 1'b1;
            in_opcode = 8'(op);
            in_dst    = DV[di];
            in_src    = SV[si];
            in_imm    = IV[ii];
            model(in_opcode, in_dst, in_src, in_imm, 1'b1, e1, i1);
            model(in_opcode, in_dst, in_src, in_imm, 1'b0, e2, i2);
            po = in_opcode;
            pend = 1'b1;
          end
        end
      end
    end
    @(negedge clk);
    check(tag_of(po, 1'b1), out_valid, out_result, out_illegal, e1, i1, po);
    check(tag_of(po, 1'b0), nx_out_valid, nx_out_result, nx_out_illegal, e2, i2, po);
    in_valid = 1'b0;
    @(negedge clk);

    // R10: back-pressure
    out_ready = 1'b0;
    opa = 8'h0F; // ADD, register operand, 64-bit
    in_valid = 1'b1; in_opcode = opa; in_dst = 64'd100; in_src = 64'd23; in_imm = 32'd0;
    model(opa, 64'd100, 64'd23, 32'd0, 1'b1, ea, i1);
    @(negedge clk);
    opb = 8'hB4; // MOV immediate, 32-bit
    in_opcode = opb; in_imm = 32'hDEAD_BEEF;
    model(opb, 64'd100, 64'd23, 32'hDEAD_BEEF, 1'b1, eb, i2);
    @(negedge clk);
    total++;
    if (in_ready !== 1'b0) begin
      bad++;
      $display("FAIL R10 in_ready got %0b expected 0", in_ready);
    end
    check("R10", out_valid, out_result, out_illegal, ea, i1, opa);
    out_ready = 1'b1;
    @(negedge clk);
    check("R10", out_valid, out_result, out_illegal, eb, i2, opb);
    in_valid = 1'b0;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R10 out_valid got %0b expected 0", out_valid);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule